// File: doc/BRIEF.md
# External Bus Chip-Select Controller

This block connects a single on-chip master to an external parallel memory bus that runs on the same clock. A request carries a word address, a direction, four byte enables and 32 bits of write data, and travels on a valid/ready handshake. The top bits of the address pick one of eight areas. Each area has its own active-low chip select and its own timing word. The timing word sets the bus width (8 or 16 bits), the byte order, the write-strobe style, the chip-select and strobe edges, the data-drive window, the normal and page wait counts, and the recovery gaps after a read and after a write.

A master access is cut into external cycles. An 8-bit area gets one cycle for each enabled byte, and a 16-bit area gets one cycle for each halfword that holds an enabled byte. The cycles run in ascending address order. A write is taken into a one-entry buffer in the accepting cycle, so the master moves on while the buffered cycles play out. A read answers with a one-cycle `rsp_valid` pulse after its last cycle. The master must accept that pulse, because the response has no back-pressure. `req_ready` falls while any external cycle or recovery gap is in progress. A request offered then stays pending, with all its fields held, until `req_ready` returns. The data pad is split into `d_out`, `d_oe` and `d_in`, and the tristate buffer sits outside the block.

Top module: `ebc_cs_ctrl`

## Requirements
- R1: The timing word of each area is 29 bits wide: bit 0 sel16 (1 = 16-bit area), bit 1 bigend, bit 2 bytestrobe, [4:3] cs_lead, [6:5] stb_lead, [11:7] wait_n, [14:12] wait_p, [16:15] cs_tail, [18:17] dq_lead, [20:19] dq_tail, [24:21] rec_rd, [28:25] rec_wr. The word is sampled when a request is accepted.
- R2: After reset, all chip selects, rd_n, wr_n, wr0_n, wr1_n, ble_n and bhe_n are high, d_oe is low and req_ready is high.
- R3: Address bits [23:21] select the area. Only that area's chip select can go low, and never more than one chip select is low at once.
- R4: In an 8-bit area, each enabled byte k (0..3) gets its own cycle, with ext_addr = word base + k. In a 16-bit area, each halfword h whose byte enables are not both zero gets a cycle at word base + 2h. Cycles run in ascending order.
- R5: Within a cycle counted from t=0, the strobe is low for stb_lead <= t < E, where E = stb_lead + wait + 1. The chip select is low for min(cs_lead, stb_lead) <= t < E + cs_tail, and the cycle lasts E + cs_tail clocks.
- R6: The first cycle of an access uses wait_n. Every later cycle of the same access uses wait_p.
- R7: For a write, d_oe is high for min(dq_lead, stb_lead) <= t < E + min(dq_tail, cs_tail).
- R8: Byte order: with bigend = 0, memory byte b of the word is data bits [8b+7:8b]. With bigend = 1 it is bits [8(3-b)+7:8(3-b)]. On a 16-bit bus, d[7:0] carries the even address when bigend = 0 and the odd address when bigend = 1. An 8-bit area uses d[7:0] only, and d_out[15:8] is zero there.
- R9: With bytestrobe = 0, a write strobes wr_n, and ble_n/bhe_n go low for the enabled lanes d[7:0] and d[15:8] throughout the cycle. With bytestrobe = 1, wr0_n and wr1_n strobe only the enabled low and high lanes, and ble_n/bhe_n stay high. Reads strobe rd_n.
- R10: After each external cycle, rec_rd or rec_wr idle clocks follow, with every chip select high.
- R11: A write is accepted in one clock, and req_ready stays low until its last cycle and recovery are done. A write produces no response.
- R12: Read data is taken on the last clock of the strobe. rsp_valid is high for the one clock after the last cycle ends. Bytes not covered by any cycle read as zero. Both lanes of a performed 16-bit cycle are returned.
- R13: A request offered while req_ready is low is not taken until req_ready rises, so a read never overtakes a buffered write.
- R14: An access with no byte enabled runs no external cycle. As a read, it gives rsp_valid with zero data on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every output changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| area_cfg | input | 8x29 | Timing word of each area (R1 layout) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken when high together with req_valid |
| req_addr | input | 22 | Word address, bits [23:2] of the byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables, bit b = memory byte b of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-clock read completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| cs_n | output | 8 | Active-low chip select of each area |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe, single-strobe mode |
| wr0_n | output | 1 | Low-lane write strobe, byte-strobe mode |
| wr1_n | output | 1 | High-lane write strobe, byte-strobe mode |
| ble_n | output | 1 | Low-lane enable, single-strobe mode |
| bhe_n | output | 1 | High-lane enable, single-strobe mode |
| ext_addr | output | 24 | External byte address, valid while a chip select is low |
| d_out | output | 16 | Write data to the pad |
| d_oe | output | 1 | Pad output enable |
| d_in | input | 16 | Read data from the pad |

## Verification
The bench keeps a per-clock model of every pin and compares all of them on each clock. Its stimulus targets the edge windows where counter off-by-ones hide. It uses timing words whose lead values break the ordering rules, and it checks that the clamp holds: a missing clamp would drop the chip select after the strobe or drive data late. The bench's memory returns garbage outside the strobe, so a design that samples one clock late returns the wrong word. Split accesses check that page waits apply only after the first cycle and that the lane byte order flips with bigend. A read issued right behind a posted write with the longest recovery checks that the read is held back and not slipped in ahead of the write.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int TW = 6;          // cycle timer width, holds the longest cycle
  localparam int RW = 4;          // recovery counter width
  localparam int BYTES = 4;       // master word bytes

  typedef struct packed {
    logic [3:0] rec_wr;
    logic [3:0] rec_rd;
    logic [1:0] dq_tail;
    logic [1:0] dq_lead;
    logic [1:0] cs_tail;
    logic [2:0] wait_p;
    logic [4:0] wait_n;
    logic [1:0] stb_lead;
    logic [1:0] cs_lead;
    logic       bytestrobe;
    logic       bigend;
    logic       sel16;
  } area_cfg_t;

  localparam int CFGW = $bits(area_cfg_t);

  typedef enum logic [1:0] {S_IDLE, S_CYC, S_REC} ebc_state_e;
endpackage

// File: rtl/ebc_timing.sv
module ebc_timing
  import ebc_pkg::*;
(
  input  area_cfg_t        cfg,
  input  logic             page,
  output logic [TW-1:0]    cs_start,
  output logic [TW-1:0]    st_start,
  output logic [TW-1:0]    st_end,
  output logic [TW-1:0]    cyc_end,
  output logic [TW-1:0]    do_start,
  output logic [TW-1:0]    do_end
);
  // Clamp: select and data never start after the strobe, data never outlives select.
  always_comb begin
    st_start = TW'(cfg.stb_lead);
    cs_start = (cfg.cs_lead < cfg.stb_lead) ? TW'(cfg.cs_lead) : TW'(cfg.stb_lead);
    do_start = (cfg.dq_lead < cfg.stb_lead) ? TW'(cfg.dq_lead) : TW'(cfg.stb_lead);
    st_end   = st_start + (page ? TW'(cfg.wait_p) : TW'(cfg.wait_n)) + TW'(1);
    cyc_end  = st_end + TW'(cfg.cs_tail);
    do_end   = st_end + ((cfg.dq_tail < cfg.cs_tail) ? TW'(cfg.dq_tail) : TW'(cfg.cs_tail));
  end
endmodule

// File: rtl/ebc_lanes.sv
module ebc_lanes (
  input  logic        sel16,
  input  logic        bigend,
  input  logic [1:0]  unit,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic [15:0] d_in,
  input  logic [31:0] rd_acc,
  output logic [15:0] d_out,
  output logic [1:0]  lane_en,
  output logic [31:0] rd_next
);
  logic [1:0] bpos;
  logic       hpos;

  always_comb begin
    bpos    = bigend ? (2'd3 - unit) : unit;
    hpos    = bigend ? ~unit[0] : unit[0];
    rd_next = rd_acc;
    if (sel16) begin
      d_out      = wdata[{hpos, 4'b0000} +: 16];
      lane_en[0] = bigend ? be[{unit[0], 1'b1}] : be[{unit[0], 1'b0}];
      lane_en[1] = bigend ? be[{unit[0], 1'b0}] : be[{unit[0], 1'b1}];
      rd_next[{hpos, 4'b0000} +: 16] = d_in;
    end else begin
      d_out   = {8'h00, wdata[{bpos, 3'b000} +: 8]};
      lane_en = 2'b01;
      rd_next[{bpos, 3'b000} +: 8] = d_in[7:0];
    end
  end
endmodule

// File: rtl/ebc_cs_ctrl.sv
module ebc_cs_ctrl
  import ebc_pkg::*;
#(
  parameter int AW     = 24,
  parameter int N_AREA = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_AREA-1:0][CFGW-1:0]  area_cfg,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [AW-1:2]                req_addr,
  input  logic                         req_we,
  input  logic [BYTES-1:0]             req_be,
  input  logic [8*BYTES-1:0]           req_wdata,
  output logic                         rsp_valid,
  output logic [8*BYTES-1:0]           rsp_rdata,
  output logic [N_AREA-1:0]            cs_n,
  output logic                         rd_n,
  output logic                         wr_n,
  output logic                         wr0_n,
  output logic                         wr1_n,
  output logic                         ble_n,
  output logic                         bhe_n,
  output logic [AW-1:0]                ext_addr,
  output logic [15:0]                  d_out,
  output logic                         d_oe,
  input  logic [15:0]                  d_in
);
  localparam int AB = $clog2(N_AREA);
  localparam int DW = 8 * BYTES;

  ebc_state_e        state_q;
  logic [TW-1:0]     t_q;
  logic [RW-1:0]     rc_q;
  logic [BYTES-1:0]  mask_q, mask_in, mask_left, unit_oh;
  logic              page_q, we_q, rsp_q;
  logic [BYTES-1:0]  be_q;
  logic [DW-1:0]     wd_q, rd_q, rd_next;
  logic [AB-1:0]     area_q, req_area;
  logic [AW-1:2]     base_q;
  area_cfg_t         cfg_q, cfg_in;
  logic [1:0]        unit;
  logic [1:0]        lane_en;
  logic [RW-1:0]     rec_n;
  logic [TW-1:0]     cs_start, st_start, st_end, cyc_end, do_start, do_end;
  logic              in_cyc, cs_act, st_act;

  assign req_area = req_addr[AW-1 -: AB];
  assign cfg_in   = area_cfg[req_area];
  assign mask_in  = cfg_in.sel16 ? {2'b00, |req_be[3:2], |req_be[1:0]} : req_be;

  // current unit is the lowest one still pending
  always_comb begin
    unit = 2'd0;
    for (int i = BYTES - 1; i >= 0; i--) if (mask_q[i]) unit = i[1:0];
  end
  assign unit_oh   = BYTES'(1) << unit;
  assign mask_left = mask_q & ~unit_oh;
  assign rec_n     = we_q ? cfg_q.rec_wr : cfg_q.rec_rd;

  ebc_timing u_timing (
    .cfg(cfg_q), .page(page_q), .cs_start(cs_start), .st_start(st_start),
    .st_end(st_end), .cyc_end(cyc_end), .do_start(do_start), .do_end(do_end)
  );

  ebc_lanes u_lanes (
    .sel16(cfg_q.sel16), .bigend(cfg_q.bigend), .unit(unit), .be(be_q),
    .wdata(wd_q), .d_in(d_in), .rd_acc(rd_q), .d_out(d_out),
    .lane_en(lane_en), .rd_next(rd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      t_q     <= '0;
      rc_q    <= '0;
      mask_q  <= '0;
      page_q  <= 1'b0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      area_q  <= '0;
      base_q  <= '0;
      cfg_q   <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            area_q <= req_area;
            base_q <= req_addr;
            we_q   <= req_we;
            be_q   <= req_be;
            wd_q   <= req_wdata;
            cfg_q  <= cfg_in;
            mask_q <= mask_in;
            page_q <= 1'b0;
            t_q    <= '0;
            rd_q   <= '0;
            if (mask_in != '0) state_q <= S_CYC;
            else if (!req_we)  rsp_q   <= 1'b1;
          end
        end
        S_CYC: begin
          t_q <= t_q + 1'b1;
          if (!we_q && (t_q == st_end - 1'b1)) rd_q <= rd_next;
          if (t_q == cyc_end - 1'b1) begin
            t_q    <= '0;
            mask_q <= mask_left;
            page_q <= 1'b1;
            if (!we_q && (mask_left == '0)) rsp_q <= 1'b1;
            if (rec_n != '0) begin
              state_q <= S_REC;
              rc_q    <= rec_n;
            end else if (mask_left == '0) begin
              state_q <= S_IDLE;
            end
          end
        end
        S_REC: begin
          rc_q <= rc_q - 1'b1;
          if (rc_q == RW'(1)) state_q <= (mask_q == '0) ? S_IDLE : S_CYC;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign in_cyc = (state_q == S_CYC);
  assign cs_act = in_cyc && (t_q >= cs_start) && (t_q < cyc_end);
  assign st_act = in_cyc && (t_q >= st_start) && (t_q < st_end);

  for (genvar g = 0; g < N_AREA; g++) begin : g_cs
    assign cs_n[g] = !(cs_act && (area_q == AB'(g)));
  end

  assign req_ready = (state_q == S_IDLE);
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rd_q;
  assign rd_n  = !(st_act && !we_q);
  assign wr_n  = !(st_act && we_q && !cfg_q.bytestrobe);
  assign wr0_n = !(st_act && we_q && cfg_q.bytestrobe && lane_en[0]);
  assign wr1_n = !(st_act && we_q && cfg_q.bytestrobe && lane_en[1]);
  assign ble_n = !(in_cyc && !cfg_q.bytestrobe && lane_en[0]);
  assign bhe_n = !(in_cyc && !cfg_q.bytestrobe && lane_en[1]);
  assign d_oe  = in_cyc && we_q && (t_q >= do_start) && (t_q < do_end);
  assign ext_addr = {base_q, (cfg_q.sel16 ? {unit[0], 1'b0} : unit)};

  // R3: at most one area selected
  a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R5: any strobe lies inside an active chip select
  a_r5_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n || !wr0_n || !wr1_n) |-> !(&cs_n));
  // R9: read and write strobes never overlap
  a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wr_n && wr0_n && wr1_n));
  // R7: the pad is never driven while reading
  a_r7_oe_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> rd_n);
  // R13: while a request can be taken the bus is quiet
  a_r13_ready_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&cs_n && !d_oe));
endmodule

// File: tb/tb_ebc_cs_ctrl.sv
`timescale 1ns/1ps
module tb_ebc_cs_ctrl;
  typedef struct packed {
    logic [7:0]  cs;
    logic        rd, wr, wr0, wr1, ble, bhe, oe;
    logic [15:0] dout;
    logic [23:0] addr;
    logic        rdy;
    logic        rsp_next;
  } frame_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0][28:0] area_cfg;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rd_n, wr_n, wr0_n, wr1_n, ble_n, bhe_n, d_oe;
  logic [31:0] rsp_rdata;
  logic [7:0] cs_n;
  logic [23:0] ext_addr;
  logic [15:0] d_out, d_in;

  always #10 clk = ~clk;

  function automatic logic [15:0] mem_of(input logic [23:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h31};
  endfunction
  assign d_in = !rd_n ? mem_of(ext_addr) : 16'hDEAD;

  ebc_cs_ctrl dut (
    .clk(clk), .rst_n(rst_n), .area_cfg(area_cfg), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_we(req_we), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .wr0_n(wr0_n), .wr1_n(wr1_n),
    .ble_n(ble_n), .bhe_n(bhe_n), .ext_addr(ext_addr), .d_out(d_out),
    .d_oe(d_oe), .d_in(d_in)
  );

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  frame_t q[$];
  logic [31:0] rdq[$];
  bit model_idle = 1'b1;
  bit rsp_arm = 1'b0;

  function automatic frame_t idle_frame();
    frame_t f;
    f = '0;
    f.cs = 8'hFF; f.rd = 1; f.wr = 1; f.wr0 = 1; f.wr1 = 1; f.ble = 1; f.bhe = 1;
    f.rdy = 1;
    return f;
  endfunction

  function automatic logic [28:0] mk(input int s16, big, bs, csl, stl, wn, wp, cst, dql, dqt, rr, rw);
    logic [28:0] c;
    c = '0;
    c[0] = s16[0]; c[1] = big[0]; c[2] = bs[0];
    c[4:3] = csl[1:0]; c[6:5] = stl[1:0]; c[11:7] = wn[4:0]; c[14:12] = wp[2:0];
    c[16:15] = cst[1:0]; c[18:17] = dql[1:0]; c[20:19] = dqt[1:0];
    c[24:21] = rr[3:0]; c[28:25] = rw[3:0];
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // one clock: wait for the falling edge, compare every pin against the model
  task automatic step();
    frame_t f;
    bit exp_rsp;
    logic [31:0] er;
    @(negedge clk);
    exp_rsp = rsp_arm;
    rsp_arm = 1'b0;
    model_idle = (q.size() == 0);
    f = model_idle ? idle_frame() : q.pop_front();
    if (f.rsp_next) rsp_arm = 1'b1;
    chk(cs_n == f.cs, "R1 R3 R5", "cs_n", 32'(cs_n), 32'(f.cs));
    chk(rd_n == f.rd && wr_n == f.wr, "R5 R6 R9", "rd_n/wr_n",
        {30'b0, rd_n, wr_n}, {30'b0, f.rd, f.wr});
    chk(wr0_n == f.wr0 && wr1_n == f.wr1, "R9", "wr0_n/wr1_n",
        {30'b0, wr0_n, wr1_n}, {30'b0, f.wr0, f.wr1});
    chk(ble_n == f.ble && bhe_n == f.bhe, "R9", "ble_n/bhe_n",
        {30'b0, ble_n, bhe_n}, {30'b0, f.ble, f.bhe});
    chk(d_oe == f.oe, "R7", "d_oe", 32'(d_oe), 32'(f.oe));
    if (f.oe) chk(d_out == f.dout, "R8", "d_out", 32'(d_out), 32'(f.dout));
    if (f.cs != 8'hFF) chk(ext_addr == f.addr, "R4", "ext_addr", 32'(ext_addr), 32'(f.addr));
    chk(req_ready == f.rdy, "R2 R10 R11 R13", "req_ready", 32'(req_ready), 32'(f.rdy));
    chk(rsp_valid == exp_rsp, "R12 R14", "rsp_valid", 32'(rsp_valid), 32'(exp_rsp));
    if (exp_rsp) begin
      er = (rdq.size() != 0) ? rdq.pop_front() : 32'hFFFF_FFFF;
      chk(rsp_rdata == er, "R8 R12", "rsp_rdata", rsp_rdata, er);
    end
  endtask

  // model: expected pin frames for one accepted access
  task automatic push_txn(input logic [23:0] ba, input bit we, input logic [3:0] be,
                          input logic [31:0] wd);
    logic [28:0] c;
    logic [7:0] m [4];
    logic [7:0] rm [4];
    logic [31:0] rexp;
    int area, nunits, first, lo, hi, W, E, L, cse, don, dte, R, stl;
    bit s16, big, bs, l0, l1;
    logic [15:0] dd, din;
    logic [23:0] ua;
    frame_t f;
    area = int'(ba[23:21]);
    c = area_cfg[area];
    s16 = c[0]; big = c[1]; bs = c[2];
    stl = int'(c[6:5]);
    cse = (int'(c[4:3]) < stl) ? int'(c[4:3]) : stl;
    don = (int'(c[18:17]) < stl) ? int'(c[18:17]) : stl;
    dte = (int'(c[20:19]) < int'(c[16:15])) ? int'(c[20:19]) : int'(c[16:15]);
    R = we ? int'(c[28:25]) : int'(c[24:21]);
    for (int b = 0; b < 4; b++) begin
      m[b] = big ? wd[8*(3-b) +: 8] : wd[8*b +: 8];
      rm[b] = 8'h00;
    end
    nunits = 0; first = 1;
    for (int u = 0; u < (s16 ? 2 : 4); u++) begin
      if (s16 ? (be[2*u] | be[2*u+1]) : be[u]) begin
        if (s16) begin
          lo = big ? 2*u + 1 : 2*u;
          hi = big ? 2*u : 2*u + 1;
          dd = {m[hi], m[lo]};
          l0 = be[lo]; l1 = be[hi];
          ua = {ba[23:2], 2'(2*u)};
        end else begin
          lo = u; hi = u;
          dd = {8'h00, m[u]};
          l0 = 1'b1; l1 = 1'b0;
          ua = {ba[23:2], 2'(u)};
        end
        din = mem_of(ua);
        if (s16) begin rm[lo] = din[7:0]; rm[hi] = din[15:8]; end
        else rm[u] = din[7:0];
        W = (first ? int'(c[11:7]) : int'(c[14:12])) + 1;
        E = stl + W;
        L = E + int'(c[16:15]);
        for (int t = 0; t < L; t++) begin
          f = idle_frame();
          f.rdy = 0;
          if (t >= cse) f.cs[area] = 1'b0;
          if (t >= stl && t < E) begin
            if (!we) f.rd = 0;
            else if (!bs) f.wr = 0;
            else begin f.wr0 = !l0; f.wr1 = !l1; end
          end
          if (!bs) begin f.ble = !l0; f.bhe = !l1; end
          if (we && t >= don && t < E + dte) begin f.oe = 1; f.dout = dd; end
          f.addr = ua;
          q.push_back(f);
        end
        for (int r = 0; r < R; r++) begin
          f = idle_frame(); f.rdy = 0; q.push_back(f);
        end
        first = 0;
        nunits++;
      end
    end
    if (!we) begin
      rexp = '0;
      for (int b = 0; b < 4; b++) begin
        if (big) rexp[8*(3-b) +: 8] = rm[b];
        else     rexp[8*b +: 8] = rm[b];
      end
      rdq.push_back(rexp);
      if (nunits == 0) rsp_arm = 1'b1;
      else begin
        // flag the last cycle frame of the access (before its recovery)
        for (int i = q.size() - 1; i >= 0; i--)
          if (q[i].cs != 8'hFF) begin q[i].rsp_next = 1'b1; break; end
      end
    end
  endtask

  task automatic issue(input logic [23:0] ba, input bit we, input logic [3:0] be,
                       input logic [31:0] wd);
    req_addr = ba[23:2]; req_we = we; req_be = be; req_wdata = wd; req_valid = 1'b1;
    while (!model_idle) step();   // R13: held until ready
    push_txn(ba, we, be, wd);
    step();
    req_valid = 1'b0;
  endtask

  initial begin
    area_cfg[0] = mk(1, 0, 0, 0, 1, 2, 0, 1, 0, 1, 1, 2);
    area_cfg[1] = mk(0, 1, 1, 1, 1, 1, 0, 0, 1, 0, 0, 1);
    area_cfg[2] = mk(1, 1, 1, 0, 2, 0, 1, 2, 1, 2, 3, 0);
    area_cfg[3] = '0;
    area_cfg[4] = '0;
    area_cfg[5] = mk(1, 0, 0, 3, 1, 3, 2, 1, 3, 3, 0, 0);   // clamp case
    area_cfg[6] = '0;
    area_cfg[7] = mk(0, 0, 0, 0, 0, 5, 2, 1, 0, 0, 2, 15);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    step();                                   // R2 reset state
    step();
    issue(24'h000104, 1, 4'hF, 32'h1122_3344);   // 16-bit little single
    issue(24'h000104, 0, 4'hF, 32'h0);
    issue(24'h400008, 1, 4'b0010, 32'hA1B2_C3D4); // 16-bit big byte-strobe
    issue(24'h400008, 1, 4'hF, 32'h5566_7788);
    issue(24'h400008, 0, 4'b1000, 32'h0);
    issue(24'h200230, 1, 4'hF, 32'hCAFE_F00D);   // 8-bit big, split
    issue(24'h200230, 0, 4'hF, 32'h0);
    issue(24'hA00F0C, 1, 4'b0011, 32'h1357_9BDF); // clamped timing
    issue(24'hA00F0C, 0, 4'b1100, 32'h0);
    issue(24'hE0001C, 1, 4'b1010, 32'hDEAD_BEEF); // long write recovery
    issue(24'hE0001C, 0, 4'hF, 32'h0);            // read held behind it
    issue(24'h000104, 0, 4'h0, 32'h0);            // R14 empty read
    issue(24'h000104, 1, 4'h0, 32'h0);            // R14 empty write
    issue(24'h200230, 0, 4'b0100, 32'h0);
    while (!model_idle) step();
    repeat (3) step();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule